// File: doc/BRIEF.md
# Thermal Sensor Auto-Monitor

This controller runs a temperature sensor converter without software help. While automatic mode is on, a free-running period counter starts a sampling round at a fixed interval. In each round the channels are converted in ascending index order through a request/done handshake. The block keeps the newest raw code of each channel. It checks that code against two limits per channel, an alarm limit and a shutdown limit. Each limit has its own run-length filter, so a single noisy reading cannot trip it.

When a channel's alarm filter trips, a write-one-to-clear pending bit is set, and an interrupt follows if it is enabled. The sampling interval also drops to a shorter high-temperature value until that channel reads below its alarm limit again. When a channel's shutdown filter trips while the channel is armed, the event is latched until reset. It is sent either to a reset-controller request line or to an external pin whose active level is programmable. Software uses a small register port with read and write strobes.

By default a reading is over a limit when its code is at or above it. The `DESCENDING` parameter reverses this for sensors whose code falls as temperature rises. `CODE_W` selects a 12-bit or a 10-bit code.

Top module: `thermal_monitor`

## Requirements
- R1: After reset, `irq`, `conv_req` and `shut_rst_req` are 0 and `shut_pin` is 1 (active-low, inactive). The registers read back as follows: normal period 250, hot period 50, both filter counts 4, alarm limits 3675, shutdown limits 3718, and auto control 0.
- R2: A register read returns its value on `reg_rdata` one cycle after `reg_rd`. The map is:
  - 0x04: auto control. Bit 0 enables sampling, bit 4+n arms shutdown for channel n, and bit 8 makes the shutdown pin active-high.
  - 0x08: routing and enable. Bit n enables the interrupt for channel n, bit 4+n routes shutdown to the pin, and bit 8+n routes it to the reset request.
  - 0x0C: pending bits.
  - 0x20+4n: channel data.
  - 0x30+4n: alarm limit.
  - 0x40+4n: shutdown limit.
  - 0x60: alarm filter count.
  - 0x64: shutdown filter count.
  - 0x68: normal period.
  - 0x6C: hot period.
- R3: With bit 0 of 0x04 set, rising edges of `conv_req` are exactly one period apart, counted in clock cycles. With the bit clear, no round starts.
- R4: `conv_req` stays high until `conv_done` for each channel, with `conv_sel` going 0 then 1. On `conv_done` the code is stored in the data register of that channel.
- R5: A sample counts as over the alarm limit when code ≥ limit; a code one below the limit does not count.
- R6: Pending bit n is set on the sample that completes a run of consecutive over-limit samples of the programmed length. An under-limit sample restarts the run.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A set in the same cycle as a clear wins. `irq` is high when any pending bit is set whose enable bit is also set.
- R8: Once a channel's alarm run is complete, rounds start at the hot period. The normal period returns after that channel samples under its limit.
- R9: Shutdown of channel n latches when its shutdown run completes and bit 4+n of 0x04 is set; an unarmed channel latches nothing. The latch drives the destination routed at that moment and holds until reset.
- R10: A write to 0x08 that sets bit 4+n clears bit 8+n, even if the written value also sets 8+n.
- R11: With bit 8 of 0x04 set, `shut_pin` is 1 when asserted and 0 otherwise. With the bit clear, the levels are reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| conv_req | output | 1 | Conversion request, held until done |
| conv_sel | output | 1 | Channel being converted (width log2 of channel count) |
| conv_done | input | 1 | Converter result valid |
| conv_code | input | 12 | Converter result code (`CODE_W`) |
| irq | output | 1 | Alarm interrupt |
| shut_rst_req | output | 1 | Shutdown request to reset controller |
| shut_pin | output | 1 | Shutdown pin, polarity programmable |

## Verification
The sharp collision is a software write-one-to-clear on a pending bit landing in the same cycle as the converter result that completes the alarm run. The bench waits for the edge where it drives `conv_done` for channel 0 on the final over-limit sample of a run and pulses the clear write on that same cycle. The pending bit read back afterwards must still be 1. A separate clear on a quiet cycle must drop it, which shows that the set, and not a lost write, decided the outcome.

// File: rtl/thermal_monitor.sv
module thermal_monitor #(
  parameter int NUM_CH        = 2,
  parameter int CODE_W        = 12,
  parameter bit DESCENDING    = 1'b0,
  parameter int PER_W         = 16,
  parameter int DEB_W         = 8,
  parameter int ALARM_CODE    = 3675,
  parameter int SHUT_CODE     = 3718,
  parameter int NORM_PERIOD   = 250,
  parameter int HOT_PERIOD    = 50,
  parameter int DEB_COUNT     = 4,
  parameter int SEL_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              conv_req,
  output logic [SEL_W-1:0]  conv_sel,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              irq,
  output logic              shut_rst_req,
  output logic              shut_pin
);

  localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

  logic              auto_en, pol_high, busy;
  logic [SEL_W-1:0]  sel;
  logic [DEB_W-1:0]  alm_deb, sht_deb, alm_lim, sht_lim;
  logic [PER_W-1:0]  per_norm, per_hot, tick, cur_per;
  logic [PER_W:0]    tick_inc;
  logic              wrap;
  logic [NUM_CH-1:0] arm_v, ie_v, rp_v, rr_v, pend_v, hot_v, hp_v, hr_v;
  logic [NUM_CH-1:0][CODE_W-1:0] data_v, athr_v, sthr_v;
  logic [31:0]       rd_val;
  logic              unused_wbits;

  wire wr_auto = reg_wr && reg_addr == 8'h04;
  wire wr_ien  = reg_wr && reg_addr == 8'h08;
  wire wr_pend = reg_wr && reg_addr == 8'h0C;

  assign unused_wbits = ^reg_wdata[31:16];
  assign alm_lim  = (alm_deb == '0) ? DEB_W'(1) : alm_deb;
  assign sht_lim  = (sht_deb == '0) ? DEB_W'(1) : sht_deb;
  assign cur_per  = (|hot_v) ? per_hot : per_norm;
  assign tick_inc = {1'b0, tick} + 1'b1;
  assign wrap     = tick_inc >= {1'b0, cur_per};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en  <= 1'b0;
      pol_high <= 1'b0;
      alm_deb  <= DEB_W'(DEB_COUNT);
      sht_deb  <= DEB_W'(DEB_COUNT);
      per_norm <= PER_W'(NORM_PERIOD);
      per_hot  <= PER_W'(HOT_PERIOD);
    end else if (reg_wr) begin
      case (reg_addr)
        8'h04: begin auto_en <= reg_wdata[0]; pol_high <= reg_wdata[8]; end
        8'h60: alm_deb  <= reg_wdata[DEB_W-1:0];
        8'h64: sht_deb  <= reg_wdata[DEB_W-1:0];
        8'h68: per_norm <= reg_wdata[PER_W-1:0];
        8'h6C: per_hot  <= reg_wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      busy <= 1'b0;
      sel  <= '0;
    end else begin
      if (!auto_en || wrap) tick <= '0;
      else                  tick <= tick_inc[PER_W-1:0];
      if (!busy) begin
        if (auto_en && wrap) begin
          busy <= 1'b1;
          sel  <= '0;
        end
      end else if (conv_done) begin
        if (sel == LAST_CH) busy <= 1'b0;
        else                sel  <= sel + 1'b1;
      end
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [CODE_W-1:0] data_r, athr_r, sthr_r;
    logic [DEB_W-1:0]  acnt, scnt, anext, snext;
    logic              arm_r, ie_r, rp_r, rr_r, pend_r, hot_r, hp_r, hr_r;
    logic              aover, sover, areach, sreach, afire, take;

    assign take   = busy && conv_done && sel == SEL_W'(n);
    assign aover  = DESCENDING ? (conv_code <= athr_r) : (conv_code >= athr_r);
    assign sover  = DESCENDING ? (conv_code <= sthr_r) : (conv_code >= sthr_r);
    assign anext  = !aover ? '0 : (acnt >= alm_lim) ? acnt : acnt + 1'b1;
    assign snext  = !sover ? '0 : (scnt >= sht_lim) ? scnt : scnt + 1'b1;
    assign areach = aover && anext >= alm_lim;
    assign sreach = sover && snext >= sht_lim;
    assign afire  = areach && acnt < alm_lim;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_r <= '0;
        athr_r <= CODE_W'(ALARM_CODE);
        sthr_r <= CODE_W'(SHUT_CODE);
        acnt   <= '0;
        scnt   <= '0;
        arm_r  <= 1'b0;
        ie_r   <= 1'b0;
        rp_r   <= 1'b0;
        rr_r   <= 1'b0;
        pend_r <= 1'b0;
        hot_r  <= 1'b0;
        hp_r   <= 1'b0;
        hr_r   <= 1'b0;
      end else begin
        if (reg_wr && reg_addr == 8'(8'h30 + 4 * n)) athr_r <= reg_wdata[CODE_W-1:0];
        if (reg_wr && reg_addr == 8'(8'h40 + 4 * n)) sthr_r <= reg_wdata[CODE_W-1:0];
        if (wr_auto) arm_r <= reg_wdata[4+n];
        if (wr_ien) begin
          ie_r <= reg_wdata[n];
          rp_r <= reg_wdata[4+n];
          rr_r <= reg_wdata[8+n] && !reg_wdata[4+n];
        end
        if (take) begin
          data_r <= conv_code;
          acnt   <= anext;
          scnt   <= snext;
          hot_r  <= areach;
        end
        if (take && afire)                pend_r <= 1'b1;
        else if (wr_pend && reg_wdata[n]) pend_r <= 1'b0;
        if (take && sreach && arm_r) begin
          hp_r <= hp_r | rp_r;
          hr_r <= hr_r | rr_r;
        end
      end
    end

    assign data_v[n] = data_r;
    assign athr_v[n] = athr_r;
    assign sthr_v[n] = sthr_r;
    assign arm_v[n]  = arm_r;
    assign ie_v[n]   = ie_r;
    assign rp_v[n]   = rp_r;
    assign rr_v[n]   = rr_r;
    assign pend_v[n] = pend_r;
    assign hot_v[n]  = hot_r;
    assign hp_v[n]   = hp_r;
    assign hr_v[n]   = hr_r;
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      8'h04: begin
        rd_val[0] = auto_en;
        rd_val[8] = pol_high;
        rd_val[4 +: NUM_CH] = arm_v;
      end
      8'h08: begin
        rd_val[0 +: NUM_CH] = ie_v;
        rd_val[4 +: NUM_CH] = rp_v;
        rd_val[8 +: NUM_CH] = rr_v;
      end
      8'h0C: rd_val[0 +: NUM_CH] = pend_v;
      8'h60: rd_val[DEB_W-1:0] = alm_deb;
      8'h64: rd_val[DEB_W-1:0] = sht_deb;
      8'h68: rd_val[PER_W-1:0] = per_norm;
      8'h6C: rd_val[PER_W-1:0] = per_hot;
      default: ;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (reg_addr == 8'(8'h20 + 4 * n)) rd_val[CODE_W-1:0] = data_v[n];
      if (reg_addr == 8'(8'h30 + 4 * n)) rd_val[CODE_W-1:0] = athr_v[n];
      if (reg_addr == 8'(8'h40 + 4 * n)) rd_val[CODE_W-1:0] = sthr_v[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assign conv_req     = busy;
  assign conv_sel     = sel;
  assign irq          = |(pend_v & ie_v);
  assign shut_rst_req = |hr_v;
  assign shut_pin     = pol_high ? (|hp_v) : !(|hp_v);

endmodule

// File: rtl/thermal_monitor_chk.sv
module thermal_monitor_chk #(
  parameter int NUM_CH = 2,
  parameter int SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_en,
  input logic              conv_req,
  input logic              conv_done,
  input logic [SEL_W-1:0]  conv_sel,
  input logic [NUM_CH-1:0] pend_v,
  input logic [NUM_CH-1:0] rp_v,
  input logic [NUM_CH-1:0] rr_v,
  input logic [NUM_CH-1:0] hp_v,
  input logic              shut_rst_req
);

  assert_round_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(auto_en));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req);

  assert_rst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shut_rst_req |=> shut_rst_req);

  assert_pin_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hp_v) |=> (|hp_v));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_v[n]) |-> $past(conv_done && conv_sel == SEL_W'(n)));

    assert_route_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rp_v[n] && rr_v[n]));
  end

endmodule

bind thermal_monitor thermal_monitor_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .conv_req(conv_req),
  .conv_done(conv_done), .conv_sel(conv_sel), .pend_v(pend_v), .rp_v(rp_v),
  .rr_v(rr_v), .hp_v(hp_v), .shut_rst_req(shut_rst_req)
);

// File: tb/thermal_monitor_tb.sv
module thermal_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int THR_A = 1000;
  localparam int THR_S = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        conv_req, conv_done = 1'b0;
  logic [0:0]  conv_sel;
  logic [11:0] conv_code = '0;
  logic        irq, shut_rst_req, shut_pin;

  logic [11:0] code_in [2];
  int total = 0, bad = 0;
  int cyc = 0, rounds = 0, rise_cnt = 0, rise_time = 0, rise_gap = 0;
  logic req_prev = 1'b0;
  logic [31:0] rv;
  int g;

  thermal_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .conv_req(conv_req), .conv_sel(conv_sel), .conv_done(conv_done),
    .conv_code(conv_code), .irq(irq), .shut_rst_req(shut_rst_req), .shut_pin(shut_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (conv_req && !conv_done) begin
      conv_done <= 1'b1;
      conv_code <= code_in[conv_sel];
    end else begin
      conv_done <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (conv_done && conv_sel == 1'b1) rounds++;
  end

  always @(negedge clk) begin
    if (conv_req && !req_prev) begin
      rise_cnt++;
      rise_gap = cyc - rise_time;
      rise_time = cyc;
    end
    req_prev = conv_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_rounds(input int n);
    int t;
    t = rounds + n;
    while (rounds < t) @(negedge clk);
  endtask

  task automatic gap(output int gv);
    int k;
    k = rise_cnt;
    while (rise_cnt < k + 2) @(negedge clk);
    gv = rise_gap;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    code_in[0] = 12'd500;
    code_in[1] = 12'd700;
    do_reset();

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 conv_req", conv_req, 0);
    chk("R1 shut_rst_req", shut_rst_req, 0);
    chk("R1 shut_pin", shut_pin, 1);
    rd(8'h68, rv); chk("R1 R2 normal period", rv, 250);
    rd(8'h6C, rv); chk("R1 R2 hot period", rv, 50);
    rd(8'h60, rv); chk("R1 R2 alarm count", rv, 4);
    rd(8'h64, rv); chk("R1 R2 shut count", rv, 4);
    rd(8'h34, rv); chk("R1 R2 alarm limit", rv, 3675);
    rd(8'h40, rv); chk("R1 R2 shut limit", rv, 3718);
    rd(8'h04, rv); chk("R1 R2 auto control", rv, 0);

    // R3 disabled: no rounds
    repeat (300) @(negedge clk);
    chk("R3 no request while disabled", rise_cnt, 0);

    wr(8'h68, 20); wr(8'h6C, 8); wr(8'h60, 3); wr(8'h64, 3);
    for (int n = 0; n < 2; n++) begin
      wr(8'(8'h30 + 4*n), THR_A);
      wr(8'(8'h40 + 4*n), THR_S);
    end
    wr(8'h08, 32'h213);
    rd(8'h08, rv); chk("R2 routing readback", rv, 32'h213);
    wr(8'h04, 32'h11);

    gap(g); chk("R3 normal period", g, 20);
    wait_rounds(1);
    rd(8'h20, rv); chk("R4 ch0 data", rv, 500);
    rd(8'h24, rv); chk("R4 ch1 data", rv, 700);

    // R5 threshold sweep around the alarm limit
    for (int d = -3; d <= 3; d++) begin
      code_in[0] = 12'd500;
      wait_rounds(1);
      wr(8'h0C, 32'h3);
      code_in[0] = 12'(THR_A + d);
      wait_rounds(3);
      rd(8'h0C, rv);
      chk($sformatf("R5 compare offset %0d", d), rv[0], (d >= 0) ? 1 : 0);
      chk($sformatf("R7 irq offset %0d", d), irq, (d >= 0) ? 1 : 0);
    end

    // R6 run length
    code_in[0] = 12'd500; wait_rounds(1); wr(8'h0C, 32'h3);
    code_in[0] = 12'(THR_A); wait_rounds(2);
    rd(8'h0C, rv); chk("R6 two over samples", rv[0], 0);
    code_in[0] = 12'd500; wait_rounds(1);
    code_in[0] = 12'(THR_A); wait_rounds(2);
    rd(8'h0C, rv); chk("R6 run restarted", rv[0], 0);
    wait_rounds(1);
    rd(8'h0C, rv); chk("R6 third over sample", rv[0], 1);

    // R8 hot period
    gap(g); gap(g); chk("R8 hot period", g, 8);
    code_in[0] = 12'd500; wait_rounds(1);
    gap(g); gap(g); chk("R8 back to normal", g, 20);

    // R7 enable masking and write-one-to-clear
    wr(8'h08, 32'h212);
    chk("R7 irq masked", irq, 0);
    rd(8'h0C, rv); chk("R7 pending kept while masked", rv[0], 1);
    wr(8'h08, 32'h213);
    chk("R7 irq unmasked", irq, 1);
    wr(8'h0C, 32'h0);
    rd(8'h0C, rv); chk("R7 write zero no effect", rv[0], 1);
    wr(8'h0C, 32'h1);
    rd(8'h0C, rv); chk("R7 write one clears", rv[0], 0);
    chk("R7 irq after clear", irq, 0);

    // R7 set and clear in the same cycle
    code_in[0] = 12'(THR_A); wait_rounds(2);
    do begin
      @(negedge clk); #1;
    end while (!(conv_req && conv_done && conv_sel == 1'b0));
    reg_addr = 8'h0C; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h0C, rv); chk("R7 set wins over clear", rv[0], 1);
    wr(8'h0C, 32'h1);
    rd(8'h0C, rv); chk("R7 quiet clear", rv[0], 0);
    code_in[0] = 12'd500; wait_rounds(1);

    // R9 shutdown
    code_in[1] = 12'd2500; wait_rounds(5);
    chk("R9 unarmed channel ignored", shut_rst_req, 0);
    code_in[0] = 12'(THR_S + 1); wait_rounds(2);
    chk("R9 pin before run complete", shut_pin, 1);
    wait_rounds(1);
    chk("R9 R11 pin asserted low", shut_pin, 0);
    chk("R9 reset route untouched", shut_rst_req, 0);
    code_in[0] = 12'd500; wait_rounds(3);
    chk("R9 pin sticky", shut_pin, 0);
    wr(8'h04, 32'h31); wait_rounds(1);
    chk("R9 armed channel to reset request", shut_rst_req, 1);

    do_reset();
    chk("R9 cleared by reset pin", shut_pin, 1);
    chk("R9 cleared by reset request", shut_rst_req, 0);

    // R10 route exclusivity
    wr(8'h08, 32'h110);
    rd(8'h08, rv); chk("R10 pin route wins", rv, 32'h010);
    wr(8'h08, 32'h100);
    rd(8'h08, rv); chk("R10 reset route alone", rv, 32'h100);

    // R11 polarity
    wr(8'h04, 32'h100);
    chk("R11 high-active inactive", shut_pin, 0);
    wr(8'h68, 20); wr(8'h08, 32'h010);
    code_in[0] = 12'd3800; code_in[1] = 12'd0;
    wr(8'h04, 32'h111);
    wait_rounds(4);
    chk("R11 high-active asserted", shut_pin, 1);

    finish_run();
  end
endmodule